// File: doc/BRIEF.md
# Byte-Serial Rotator and Normalizer

This block holds a 32-bit operand behind one byte-wide register port. The host fills the operand with four byte writes, least significant byte first, then writes a control byte that starts a command. A nonzero shift amount in that byte rotates the operand by that many bit positions, left or right. A shift amount of zero starts a normalize instead. Normalize moves the operand left until its top bit is set and writes the number of positions moved back into the amount field. Software can then treat the operand as a mantissa and the amount as an exponent.

A command runs for a fixed number of cycles while a busy flag is set. When the flag drops, the result is read back with four byte reads, most significant byte first, and the updated amount is read from the control byte. While busy is set the block ignores every register access.

Top module: `bshift_norm`

## Requirements
- R1: With `sel_i`=0 and busy low, each `wr_i` pulse stores `wdata_i` into the next operand byte. The first byte after reset or after an accepted control write is bits 7:0, and the pointer climbs to bits 31:24 and then wraps.
- R2: With `sel_i`=0 and busy low, `rdata_o` shows the operand byte under the read pointer, and each `rd_i` pulse moves that pointer one byte down. The pointer starts at bits 31:24 after reset or after an accepted control write, and wraps after bits 7:0.
- R3: The control byte holds the shift amount in bits 4:0 and the direction in bit 5 (0 = left, 1 = right). Reading it returns bit 7 = busy, bit 6 = 0, bit 5 = direction and bits 4:0 = amount. A nonzero amount rotates the operand by that many positions in that direction and leaves the amount field unchanged.
- R4: An amount of zero normalizes: the operand is shifted left with zero fill until bit 31 is 1, and the amount field receives the number of positions shifted. The direction bit has no effect.
- R5: Normalizing an all-zero operand leaves it zero and sets the amount field to 31.
- R6: An accepted control write raises `busy_o` on the next cycle. `busy_o` stays high for exactly 9 cycles, and the result and the updated amount are readable in the first cycle after it falls.
- R7: An accepted control write returns the write pointer to bits 7:0 and the read pointer to bits 31:24.
- R8: While busy is high, operand writes and reads change neither the operand nor either pointer, and `rdata_o` returns 0 for operand reads.
- R9: A control write while busy is high is ignored: it neither restarts nor changes the running command.
- R10: After reset the operand is 0, the control byte reads 0, `busy_o` is low, and both pointers are at their start positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (advances the operand read pointer) |
| sel_i | input | 1 | Register select: 0 = operand, 1 = control |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte for the selected register |
| busy_o | output | 1 | High while a command runs |

## Verification
The two things that can fall in one cycle are the completion of a command, when the result is loaded into the operand, and a host access to that same operand register. The bench holds operand reads and writes, and in one run a second control write, asserted on every busy cycle, including the last one, where the result is committed. After busy falls the bench expects the rotated or normalized word and an unmoved pointer pair, and a fresh load must still land at the least significant byte. Busy-phase reads must show zero throughout.

// File: rtl/bshift_norm_pkg.sv
package bshift_norm_pkg;

  typedef enum logic {
    SEL_OPND = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  localparam int unsigned DEF_LAT = 9;

endpackage

// File: rtl/bshift_rot.sv
// Logarithmic left rotator; right rotation is requested as a negated amount.
module bshift_rot #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {stg[s][W-1-STEP:0], stg[s][W-1:W-STEP]} : stg[s];
  end

  assign data_o = stg[SW];

endmodule

// File: rtl/bshift_lzc.sv
// Leading-zero count, saturated at W-1 for an all-zero input.
module bshift_lzc #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = CW'(W - 1);
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/bshift_opreg.sv
// Operand word with independent byte write/read pointers.
module bshift_opreg #(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 8,
  localparam int unsigned NB = W / BW,
  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          ptr_clr_i,
  input  logic          load_i,
  input  logic [W-1:0]  load_data_i,
  input  logic [BW-1:0] wdata_i,
  output logic [W-1:0]  word_o,
  output logic [BW-1:0] rbyte_o
);

  localparam logic [PW-1:0] WPTR_INIT = '0;
  localparam logic [PW-1:0] RPTR_INIT = PW'(NB - 1);

  logic [W-1:0]  word_q;
  logic [PW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= load_data_i;
    end else if (wr_i) begin
      word_q[wptr_q*BW +: BW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= WPTR_INIT;
      rptr_q <= RPTR_INIT;
    end else if (ptr_clr_i) begin
      wptr_q <= WPTR_INIT;
      rptr_q <= RPTR_INIT;
    end else begin
      if (wr_i) wptr_q <= wptr_q + PW'(1);
      if (rd_i) rptr_q <= rptr_q - PW'(1);
    end
  end

  assign word_o  = word_q;
  assign rbyte_o = word_q[rptr_q*BW +: BW];

endmodule

// File: rtl/bshift_norm.sv
module bshift_norm
  import bshift_norm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LAT    = DEF_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o
);

  localparam int unsigned CW = $clog2(DATA_W);
  localparam int unsigned TW = $clog2(LAT + 1);

  logic          busy_q, norm_q, dir_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;

  logic              is_ctrl, ctrl_wr, op_wr, op_rd, done;
  logic [CW-1:0]     lz_cnt, rot_amt;
  logic [DATA_W-1:0] op_q, rot_word;
  logic [BYTE_W-1:0] op_byte, ctrl_byte;

  assign is_ctrl = (reg_sel_e'(sel_i) == SEL_CTRL);
  assign ctrl_wr = wr_i && is_ctrl && !busy_q;
  assign op_wr   = wr_i && !is_ctrl && !busy_q;
  assign op_rd   = rd_i && !is_ctrl && !busy_q;
  assign done    = busy_q && (tmr_q == '0);

  // Command sequencing: fixed latency, result committed on the last busy cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      norm_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      tmr_q  <= '0;
    end else if (ctrl_wr) begin
      busy_q <= 1'b1;
      cnt_q  <= wdata_i[CW-1:0];
      dir_q  <= wdata_i[CW];
      norm_q <= (wdata_i[CW-1:0] == '0);
      tmr_q  <= TW'(LAT - 1);
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        if (norm_q) cnt_q <= lz_cnt;
      end else begin
        tmr_q <= tmr_q - TW'(1);
      end
    end
  end

  bshift_lzc #(
    .W  (DATA_W),
    .CW (CW)
  ) lzc_i (
    .data_i (op_q),
    .cnt_o  (lz_cnt)
  );

  // Right rotate by n equals left rotate by -n; normalize is a left rotate by the zero count.
  always_comb begin
    if (norm_q)     rot_amt = lz_cnt;
    else if (dir_q) rot_amt = CW'(0) - cnt_q;
    else            rot_amt = cnt_q;
  end

  bshift_rot #(
    .W  (DATA_W),
    .SW (CW)
  ) rot_i (
    .data_i (op_q),
    .amt_i  (rot_amt),
    .data_o (rot_word)
  );

  bshift_opreg #(
    .W  (DATA_W),
    .BW (BYTE_W)
  ) opreg_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (op_wr),
    .rd_i        (op_rd),
    .ptr_clr_i   (ctrl_wr),
    .load_i      (done),
    .load_data_i (rot_word),
    .wdata_i     (wdata_i),
    .word_o      (op_q),
    .rbyte_o     (op_byte)
  );

  always_comb begin
    ctrl_byte             = '0;
    ctrl_byte[CW-1:0]     = cnt_q;
    ctrl_byte[CW]         = dir_q;
    ctrl_byte[BYTE_W-1]   = busy_q;
  end

  always_comb begin
    if (is_ctrl)     rdata_o = ctrl_byte;
    else if (busy_q) rdata_o = '0;
    else             rdata_o = op_byte;
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/bshift_norm_chk.sv
module bshift_norm_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LAT    = 9,
  localparam int unsigned CW    = $clog2(DATA_W),
  localparam int unsigned BCW   = $clog2(LAT + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              sel_i,
  input logic              busy_o,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [DATA_W-1:0] op_q,
  input logic [CW-1:0]     cnt_q,
  input logic              norm_q
);

  logic [BCW-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= '0;
    else if (busy_o) bcnt_q <= bcnt_q + BCW'(1);
    else             bcnt_q <= '0;
  end

  p_busy_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !busy_o) |=> busy_o);

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o)) |-> (bcnt_q == BCW'(LAT)));

  p_busy_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt_q < BCW'(LAT)));

  p_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sel_i) |-> (rdata_o == '0));

  p_op_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(op_q));

  p_norm_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && norm_q && (op_q != '0)) |-> op_q[DATA_W-1]);

  p_norm_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && norm_q && (op_q == '0)) |-> (cnt_q == CW'(DATA_W - 1)));

endmodule

bind bshift_norm bshift_norm_chk #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .LAT    (LAT)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .sel_i   (sel_i),
  .busy_o  (busy_o),
  .rdata_o (rdata_o),
  .op_q    (op_q),
  .cnt_q   (cnt_q),
  .norm_q  (norm_q)
);

// File: tb/bshift_norm_tb.sv
module bshift_norm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 9;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bshift_norm dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .sel_i   (sel_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .busy_o  (busy_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    if (n % 32 == 0) return x;
    return (x << (n % 32)) | (x >> (32 - n % 32));
  endfunction

  function automatic int lead_zeros(input logic [31:0] x);
    for (int i = 31; i >= 0; i--) if (x[i]) return 31 - i;
    return 31;
  endfunction

  // All tasks start and end at a falling edge.
  task automatic wr_byte(input logic s, input logic [7:0] d);
    sel_i = s; wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic load_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) wr_byte(1'b0, w[8*b +: 8]);
  endtask

  task automatic read_bytes(input int n, output logic [31:0] w);
    w = '0;
    for (int b = 0; b < n; b++) begin
      sel_i = 1'b0; rd_i = 1'b1;
      #1 w = {w[23:0], rdata_o};
      @(negedge clk_i);
      rd_i = 1'b0;
    end
  endtask

  task automatic read_ctrl(output logic [7:0] c);
    sel_i = 1'b1;
    #1 c = rdata_o;
    sel_i = 1'b0;
  endtask

  // Issue a command; optionally hammer the port on every busy cycle.
  task automatic command(input logic [7:0] c, input bit noisy, input logic [7:0] noise_ctrl);
    int cyc;
    wr_byte(1'b1, c);
    cyc = 0;
    while (busy_o) begin
      if (noisy) begin
        sel_i = 1'b0; wr_i = 1'b1; rd_i = 1'b1; wdata_i = 8'h5A;
        #1 check("R8 read while busy", {24'h0, rdata_o}, 32'h0);
        if (cyc == 3) begin
          sel_i = 1'b1; wdata_i = noise_ctrl;
          #1;
        end
      end
      @(negedge clk_i);
      wr_i = 1'b0; rd_i = 1'b0; sel_i = 1'b0;
      cyc++;
      if (cyc > 100) break;
    end
    check("R6 busy length", cyc, LAT);
  endtask

  task automatic run_op(input logic [31:0] x, input logic [7:0] c, input string req);
    logic [31:0] exp_w, got_w;
    logic [7:0]  exp_c, got_c;
    int n, lz;
    n = int'(c[4:0]);
    if (n != 0) begin
      exp_w = c[5] ? rotl(x, 32 - n) : rotl(x, n);
      exp_c = {2'b00, c[5], c[4:0]};
    end else begin
      lz = lead_zeros(x);
      exp_w = x << lz;
      exp_c = {2'b00, c[5], 5'(lz)};
    end
    load_word(x);
    command(c, 1'b0, 8'h00);
    read_bytes(4, got_w);
    check({req, " word"}, got_w, exp_w);
    read_ctrl(got_c);
    check({req, " ctrl"}, {24'h0, got_c}, {24'h0, exp_c});
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [31:0] w;
    logic [7:0]  c;
    pats[0] = 32'h8000_0001; pats[1] = 32'h1234_5678;
    pats[2] = 32'hF0E1_D2C3; pats[3] = 32'h0000_00A5;

    repeat (3) @(negedge clk_i);
    // R10: reset state
    check("R10 busy", {31'h0, busy_o}, 32'h0);
    read_ctrl(c);
    check("R10 ctrl", {24'h0, c}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_bytes(4, w);
    check("R10 operand", w, 32'h0);

    // R1/R2: load and read back, pointers wrap
    load_word(32'hA1B2_C3D4);
    read_bytes(4, w);
    check("R1 R2 load/read order", w, 32'hA1B2_C3D4);
    load_word(32'h0102_0304);
    read_bytes(4, w);
    check("R1 R2 pointer wrap", w, 32'h0102_0304);

    // R3: rotate sweep, both directions, every nonzero amount
    for (int d = 0; d < 2; d++)
      for (int n = 1; n < 32; n++)
        for (int p = 0; p < 4; p++)
          run_op(pats[p], {2'b00, 1'(d), 5'(n)}, "R3 rotate");

    // R4: normalize single and paired bits at every position, both direction values
    for (int k = 0; k < 32; k++) begin
      run_op(32'h1 << k, {2'b00, 1'(k & 1), 5'd0}, "R4 normalize");
      run_op((32'h1 << k) | 32'h1, 8'h00, "R4 normalize");
    end

    // R5: all-zero operand
    run_op(32'h0, 8'h00, "R5 zero normalize");
    run_op(32'h0, 8'h20, "R5 zero normalize");

    // R7: control write restarts both pointers
    load_word(32'hCAFE_0123);
    wr_byte(1'b0, 8'h77);
    read_bytes(1, w);
    command(8'h08, 1'b0, 8'h00);
    read_bytes(4, w);
    check("R7 read ptr restart", w, rotl({24'hFE_0123, 8'h77} , 0) == 32'h0 ? 32'h0 : rotl(32'hCAFE_0177, 8));
    wr_byte(1'b0, 8'h11);
    command(8'h01, 1'b0, 8'h00);
    load_word(32'h1357_9BDF);
    read_bytes(4, w);
    check("R7 write ptr restart", w, 32'h1357_9BDF);

    // R8/R9: accesses on every busy cycle, including the commit cycle
    load_word(32'h8421_0FF0);
    command(8'h2C, 1'b1, 8'h03);
    read_bytes(4, w);
    check("R8 R9 result after noise", w, rotl(32'h8421_0FF0, 32 - 12));
    read_ctrl(c);
    check("R9 ctrl kept", {24'h0, c}, 32'h0000_002C);
    load_word(32'h0000_F00D);
    command(8'h00, 1'b1, 8'h05);
    read_bytes(4, w);
    check("R8 normalize after noise", w, 32'hF00D_0000);
    read_ctrl(c);
    check("R9 normalize count", {24'h0, c}, 32'h0000_0010);
    load_word(32'h2468_ACE0);
    read_bytes(4, w);
    check("R8 pointers unmoved", w, 32'h2468_ACE0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule